// File: doc/BRIEF.md
# Inverse-transform row stage with zero-row skip

This block performs the row half of an 8x8 inverse cosine transform. Each accepted beat carries one row of eight signed 16-bit coefficients together with its row index (0 to 7). The row index picks one of four coefficient sets and one of eight rounding constants. The block forms four even dot products from the even-numbered inputs and four odd dot products from the odd-numbered inputs. It then combines each even/odd pair in a butterfly, which yields one output at the front of the row and its mirror at the back. Each result is shifted right arithmetically by 11 and clamped to signed 16 bits.

The arithmetic is time-multiplexed over the four lane pairs, so a non-zero row spends four cycles computing. A row whose eight inputs are all zero never enters the multiply path. Its constant result is loaded in the accepting cycle instead. The ports are a valid/ready stream in and a valid/ready stream out. The block holds one row at a time and accepts no new row until the current result has been taken.

The controller has three states. ST_IDLE waits for input with ready high. ST_CALC runs the lane pairs 0..3, one per cycle. ST_HOLD presents the result until it is taken. The transitions are as follows:
- start: ST_IDLE to ST_CALC, when a non-zero row is accepted.
- skip: ST_IDLE to ST_HOLD, when an all-zero row is accepted.
- step: ST_CALC to itself, while the lane pair index is below 3.
- done: ST_CALC to ST_HOLD, after lane pair 3.
- drain: ST_HOLD to ST_IDLE, when out_ready is high.

Top module: `idct_row_stage`

## Requirements
- R1: While rst_n is low and in the first cycle after it, out_valid is 0, in_ready is 1 and out_data is all zeros.
- R2: Sample i of a row sits at bits [16i+15:16i] of in_data and of out_data. Even sums a_k come from samples 0,2,4,6 and odd sums b_k from samples 1,3,5,7. Output k equals clamp((a_k+b_k)>>>11) and output 7-k equals clamp((a_k-b_k)>>>11) for k = 0..3. All sums and differences wrap in 32-bit two's complement.
- R3: The coefficient magnitudes (c4,c2,c6,c1,c3,c5,c7) are grouped into sets. Rows 0 and 4 use {0x4000,0x539f,0x22a3,0x58c5,0x4b42,0x3249,0x11a8}. Rows 1 and 7 use {0x58c5,0x73fc,0x300b,0x7b21,0x6862,0x45bf,0x187e}. Rows 2 and 6 use {0x539f,0x6d41,0x2d41,0x73fc,0x6254,0x41b3,0x1712}. Rows 3 and 5 use {0x4b42,0x6254,0x28ba,0x6862,0x587e,0x3b21,0x14c3}. The sums use them as follows:
  - a0 = c4*x0 + c2*x2 + c4*x4 + c6*x6
  - a1 = c4*x0 + c6*x2 - c4*x4 - c2*x6
  - a2 = c4*x0 - c6*x2 - c4*x4 + c2*x6
  - a3 = c4*x0 - c2*x2 + c4*x4 - c6*x6
  - b0 = c1*x1 + c3*x3 + c5*x5 + c7*x7
  - b1 = c3*x1 - c7*x3 - c1*x5 - c5*x7
  - b2 = c5*x1 - c1*x3 + c7*x5 + c3*x7
  - b3 = c7*x1 - c5*x3 + c3*x5 - c1*x7
- R4: A rounding constant is added to every even sum before the butterfly. By row 7 down to 0 it is 512, 512, 120, 0, 1203, 2260, 3597, 65536.
- R5: Any result above 32767 is output as 32767, and any result below -32768 is output as -32768.
- R6: An all-zero row bypasses the multipliers. It outputs eight copies of 32 for row 0, eight copies of 1 for rows 1 and 2, and zeros for rows 3 to 7. out_valid rises right after the accepting clock edge.
- R7: For a non-zero row, out_valid first reads 1 after the fourth rising edge that follows the accepting edge.
- R8: in_ready is 1 only when no row is held. From acceptance until the output is taken, in_ready is 0, and input offered in that time is ignored.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Block can accept a row |
| in_row | input | 3 | Row index of the offered row |
| in_data | input | 128 | Eight signed 16-bit coefficients, sample i at [16i+15:16i] |
| out_valid | output | 1 | Result row available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Eight signed 16-bit results, sample i at [16i+15:16i] |

## Verification
The bound checker watches the handshake on every cycle:
- the idle state after reset;
- in_ready low while a row is held;
- the output held stable under back-pressure;
- the constant result of a zero row one cycle after it is taken;
- the four-cycle latency of a non-zero row, counted by a small counter.

Only the bench scenarios can show the arithmetic. They check the per-row coefficient sets and rounders, the mirrored butterfly placement, 32-bit wrap and clamping at both rails. Each output is compared with an independent integer model over zero rows, DC-only rows, mixed-sign rows on every row index and full-scale rows.

// File: rtl/idct_row_pkg.sv
package idct_row_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int ACC_W      = 32;
    localparam int ROW_LANES  = 8;
    localparam int HALF_LANES = ROW_LANES / 2;
    localparam int ROW_SHIFT  = 11;
    localparam int ROW_IDX_W  = $clog2(ROW_LANES);
    localparam int PAIR_W     = $clog2(HALF_LANES);
    localparam int SET_W      = 2;
    localparam int MAG_W      = 3;
    localparam int ROW_W      = SAMPLE_W * ROW_LANES;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_HOLD
    } row_state_t;

    // magnitude indices inside one coefficient set
    localparam logic [MAG_W-1:0] M_C4 = 3'd0;
    localparam logic [MAG_W-1:0] M_C2 = 3'd1;
    localparam logic [MAG_W-1:0] M_C6 = 3'd2;
    localparam logic [MAG_W-1:0] M_C1 = 3'd3;
    localparam logic [MAG_W-1:0] M_C3 = 3'd4;
    localparam logic [MAG_W-1:0] M_C5 = 3'd5;
    localparam logic [MAG_W-1:0] M_C7 = 3'd6;

    // row index to coefficient set
    function automatic logic [SET_W-1:0] coef_set(input logic [ROW_IDX_W-1:0] row);
        logic [SET_W-1:0] s;
        unique case (row)
            3'd0, 3'd4: s = 2'd0;
            3'd1, 3'd7: s = 2'd1;
            3'd2, 3'd6: s = 2'd2;
            default:    s = 2'd3;
        endcase
        return s;
    endfunction

    // per-row rounding constant added to the even sums
    function automatic logic signed [ACC_W-1:0] row_rounder(input logic [ROW_IDX_W-1:0] row);
        logic signed [ACC_W-1:0] r;
        unique case (row)
            3'd0:    r = 32'sd65536;
            3'd1:    r = 32'sd3597;
            3'd2:    r = 32'sd2260;
            3'd3:    r = 32'sd1203;
            3'd4:    r = 32'sd0;
            3'd5:    r = 32'sd120;
            default: r = 32'sd512;
        endcase
        return r;
    endfunction

    // cosine magnitudes of each set
    function automatic logic signed [SAMPLE_W-1:0] coef_mag(input logic [SET_W-1:0] set,
                                                           input logic [MAG_W-1:0] idx);
        logic signed [SAMPLE_W-1:0] m;
        case ({set, idx})
            {2'd0, M_C4}: m = 16'sh4000;
            {2'd0, M_C2}: m = 16'sh539f;
            {2'd0, M_C6}: m = 16'sh22a3;
            {2'd0, M_C1}: m = 16'sh58c5;
            {2'd0, M_C3}: m = 16'sh4b42;
            {2'd0, M_C5}: m = 16'sh3249;
            {2'd0, M_C7}: m = 16'sh11a8;
            {2'd1, M_C4}: m = 16'sh58c5;
            {2'd1, M_C2}: m = 16'sh73fc;
            {2'd1, M_C6}: m = 16'sh300b;
            {2'd1, M_C1}: m = 16'sh7b21;
            {2'd1, M_C3}: m = 16'sh6862;
            {2'd1, M_C5}: m = 16'sh45bf;
            {2'd1, M_C7}: m = 16'sh187e;
            {2'd2, M_C4}: m = 16'sh539f;
            {2'd2, M_C2}: m = 16'sh6d41;
            {2'd2, M_C6}: m = 16'sh2d41;
            {2'd2, M_C1}: m = 16'sh73fc;
            {2'd2, M_C3}: m = 16'sh6254;
            {2'd2, M_C5}: m = 16'sh41b3;
            {2'd2, M_C7}: m = 16'sh1712;
            {2'd3, M_C4}: m = 16'sh4b42;
            {2'd3, M_C2}: m = 16'sh6254;
            {2'd3, M_C6}: m = 16'sh28ba;
            {2'd3, M_C1}: m = 16'sh6862;
            {2'd3, M_C3}: m = 16'sh587e;
            {2'd3, M_C5}: m = 16'sh3b21;
            {2'd3, M_C7}: m = 16'sh14c3;
            default:      m = '0;
        endcase
        return m;
    endfunction

    // Signed coefficient for lane pair k and term t.
    // Terms 0..3 multiply samples 0,2,4,6; terms 4..7 multiply samples 1,3,5,7.
    function automatic logic signed [SAMPLE_W-1:0] coef_entry(input logic [SET_W-1:0]  set,
                                                             input logic [PAIR_W-1:0] pair,
                                                             input logic [2:0]        term);
        logic             neg;
        logic [MAG_W-1:0] idx;
        logic signed [SAMPLE_W-1:0] mag;
        unique case ({pair, term})
            5'd0:  {neg, idx} = {1'b0, M_C4};
            5'd1:  {neg, idx} = {1'b0, M_C2};
            5'd2:  {neg, idx} = {1'b0, M_C4};
            5'd3:  {neg, idx} = {1'b0, M_C6};
            5'd4:  {neg, idx} = {1'b0, M_C1};
            5'd5:  {neg, idx} = {1'b0, M_C3};
            5'd6:  {neg, idx} = {1'b0, M_C5};
            5'd7:  {neg, idx} = {1'b0, M_C7};
            5'd8:  {neg, idx} = {1'b0, M_C4};
            5'd9:  {neg, idx} = {1'b0, M_C6};
            5'd10: {neg, idx} = {1'b1, M_C4};
            5'd11: {neg, idx} = {1'b1, M_C2};
            5'd12: {neg, idx} = {1'b0, M_C3};
            5'd13: {neg, idx} = {1'b1, M_C7};
            5'd14: {neg, idx} = {1'b1, M_C1};
            5'd15: {neg, idx} = {1'b1, M_C5};
            5'd16: {neg, idx} = {1'b0, M_C4};
            5'd17: {neg, idx} = {1'b1, M_C6};
            5'd18: {neg, idx} = {1'b1, M_C4};
            5'd19: {neg, idx} = {1'b0, M_C2};
            5'd20: {neg, idx} = {1'b0, M_C5};
            5'd21: {neg, idx} = {1'b1, M_C1};
            5'd22: {neg, idx} = {1'b0, M_C7};
            5'd23: {neg, idx} = {1'b0, M_C3};
            5'd24: {neg, idx} = {1'b0, M_C4};
            5'd25: {neg, idx} = {1'b1, M_C2};
            5'd26: {neg, idx} = {1'b0, M_C4};
            5'd27: {neg, idx} = {1'b1, M_C6};
            5'd28: {neg, idx} = {1'b0, M_C7};
            5'd29: {neg, idx} = {1'b1, M_C5};
            5'd30: {neg, idx} = {1'b0, M_C3};
            default: {neg, idx} = {1'b1, M_C1};
        endcase
        mag = coef_mag(set, idx);
        return neg ? -mag : mag;
    endfunction

    // clamp a wide signed value into one sample
    function automatic logic signed [SAMPLE_W-1:0] clamp_sample(input logic signed [ACC_W-1:0] v);
        logic signed [SAMPLE_W-1:0] r;
        if (v > 32'sd32767)
            r = 16'sh7fff;
        else if (v < -32'sd32768)
            r = 16'sh8000;
        else
            r = v[SAMPLE_W-1:0];
        return r;
    endfunction

    // constant result sample of an all-zero row
    function automatic logic signed [SAMPLE_W-1:0] skip_sample(input logic [ROW_IDX_W-1:0] row);
        logic signed [ACC_W-1:0] shifted;
        shifted = row_rounder(row) >>> ROW_SHIFT;
        return clamp_sample(shifted);
    endfunction

endpackage

// File: rtl/idct_row_coef_rom.sv
module idct_row_coef_rom
    import idct_row_pkg::*;
(
    input  logic [SET_W-1:0]             set_sel,
    input  logic [PAIR_W-1:0]            pair_sel,
    output logic [SAMPLE_W*ROW_LANES-1:0] coefs
);

    // one coefficient per term, computed from the set and lane pair
    for (genvar t = 0; t < ROW_LANES; t++) begin : g_term
        assign coefs[SAMPLE_W*t +: SAMPLE_W] = coef_entry(set_sel, pair_sel, 3'(t));
    end

endmodule

// File: rtl/idct_row_pair_mac.sv
module idct_row_pair_mac
    import idct_row_pkg::*;
(
    input  logic [ROW_W-1:0]              samples,
    input  logic [SAMPLE_W*ROW_LANES-1:0] coefs,
    input  logic signed [ACC_W-1:0]       rounder,
    output logic signed [ACC_W-1:0]       even_sum,
    output logic signed [ACC_W-1:0]       odd_sum
);

    logic signed [ACC_W-1:0] even_prod [HALF_LANES];
    logic signed [ACC_W-1:0] odd_prod  [HALF_LANES];

    for (genvar j = 0; j < HALF_LANES; j++) begin : g_prod
        logic signed [SAMPLE_W-1:0] xe, xo, ce, co;
        assign xe = samples[SAMPLE_W*(2*j)     +: SAMPLE_W];
        assign xo = samples[SAMPLE_W*(2*j + 1) +: SAMPLE_W];
        assign ce = coefs[SAMPLE_W*j                +: SAMPLE_W];
        assign co = coefs[SAMPLE_W*(j + HALF_LANES) +: SAMPLE_W];
        assign even_prod[j] = ACC_W'(xe) * ACC_W'(ce);
        assign odd_prod[j]  = ACC_W'(xo) * ACC_W'(co);
    end

    // 32-bit wrapping accumulation
    always_comb begin
        even_sum = rounder;
        odd_sum  = '0;
        for (int j = 0; j < HALF_LANES; j++) begin
            even_sum = even_sum + even_prod[j];
            odd_sum  = odd_sum + odd_prod[j];
        end
    end

endmodule

// File: rtl/idct_row_butterfly.sv
module idct_row_butterfly
    import idct_row_pkg::*;
(
    input  logic signed [ACC_W-1:0]    even_sum,
    input  logic signed [ACC_W-1:0]    odd_sum,
    output logic signed [SAMPLE_W-1:0] front_out,
    output logic signed [SAMPLE_W-1:0] back_out
);

    logic signed [ACC_W-1:0] plus_w, minus_w;
    logic signed [ACC_W-1:0] plus_sh, minus_sh;

    assign plus_w   = even_sum + odd_sum;
    assign minus_w  = even_sum - odd_sum;
    assign plus_sh  = plus_w >>> ROW_SHIFT;
    assign minus_sh = minus_w >>> ROW_SHIFT;

    assign front_out = clamp_sample(plus_sh);
    assign back_out  = clamp_sample(minus_sh);

endmodule

// File: rtl/idct_row_stage.sv
module idct_row_stage
    import idct_row_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ROW_IDX_W-1:0] in_row,
    input  logic [ROW_W-1:0]     in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ROW_W-1:0]     out_data
);

    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(HALF_LANES - 1);

    row_state_t           state_q, state_d;
    logic [ROW_IDX_W-1:0] row_q;
    logic [ROW_W-1:0]     samples_q;
    logic [PAIR_W-1:0]    pair_q;
    logic [ROW_W-1:0]     result_q;

    logic                 accept;
    logic                 row_is_zero;

    logic [SAMPLE_W*ROW_LANES-1:0] pair_coefs;
    logic signed [ACC_W-1:0]       even_sum, odd_sum;
    logic signed [SAMPLE_W-1:0]    front_val, back_val;

    assign accept      = in_valid && in_ready;
    assign row_is_zero = (in_data == '0);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = row_is_zero ? ST_HOLD : ST_CALC;   // skip / start
            end
            ST_CALC: begin
                if (pair_q == LAST_PAIR)
                    state_d = ST_HOLD;                           // done
            end
            ST_HOLD: begin
                if (out_ready)
                    state_d = ST_IDLE;                           // drain
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- handshake outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_CALC: in_ready  = 1'b0;
            ST_HOLD: out_valid = 1'b1;
            default: in_ready  = 1'b0;
        endcase
    end

    assign out_data = result_q;

    // ---------------- arithmetic ----------------
    idct_row_coef_rom u_rom (
        .set_sel  (coef_set(row_q)),
        .pair_sel (pair_q),
        .coefs    (pair_coefs)
    );

    idct_row_pair_mac u_mac (
        .samples  (samples_q),
        .coefs    (pair_coefs),
        .rounder  (row_rounder(row_q)),
        .even_sum (even_sum),
        .odd_sum  (odd_sum)
    );

    idct_row_butterfly u_bfly (
        .even_sum  (even_sum),
        .odd_sum   (odd_sum),
        .front_out (front_val),
        .back_out  (back_val)
    );

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q     <= '0;
            samples_q <= '0;
            pair_q    <= '0;
            result_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        row_q  <= in_row;
                        pair_q <= '0;
                        if (row_is_zero) begin
                            for (int i = 0; i < ROW_LANES; i++)
                                result_q[SAMPLE_W*i +: SAMPLE_W] <= skip_sample(in_row);
                        end else begin
                            samples_q <= in_data;
                        end
                    end
                end
                ST_CALC: begin
                    result_q[SAMPLE_W*int'(pair_q) +: SAMPLE_W] <= front_val;
                    result_q[SAMPLE_W*(ROW_LANES-1-int'(pair_q)) +: SAMPLE_W] <= back_val;
                    pair_q <= pair_q + 1'b1;
                end
                ST_HOLD: begin
                    pair_q <= '0;
                end
                default: pair_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/idct_row_stage_chk.sv
module idct_row_stage_chk
    import idct_row_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_ready,
    input  logic [ROW_IDX_W-1:0] in_row,
    input  logic [ROW_W-1:0]     in_data,
    input  logic                 out_valid,
    input  logic                 out_ready,
    input  logic [ROW_W-1:0]     out_data
);

    logic                       take;
    logic                       take_zero;
    logic                       take_busy;
    logic [2:0]                 lat_cnt;
    logic signed [SAMPLE_W-1:0] zero_exp;

    assign take      = in_valid && in_ready;
    assign take_zero = take && (in_data == '0);
    assign take_busy = take && (in_data != '0);

    // expected skip value, written from the requirement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            zero_exp <= '0;
        else if (take_zero)
            zero_exp <= (in_row == 3'd0) ? 16'sd32 :
                        (in_row == 3'd1 || in_row == 3'd2) ? 16'sd1 : 16'sd0;
    end

    // cycles since a non-zero row was taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_cnt <= '0;
        else if (take_busy)
            lat_cnt <= 3'd1;
        else if (lat_cnt != 3'd0 && lat_cnt < 3'd5)
            lat_cnt <= lat_cnt + 3'd1;
        else
            lat_cnt <= '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_zero_row_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_zero |=> (out_valid && out_data == {ROW_LANES{zero_exp}}));

    assert_calc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt != 3'd0 && lat_cnt < 3'd5) |-> (!out_valid && !in_ready));

    assert_calc_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt == 3'd5) |-> out_valid);

endmodule

bind idct_row_stage idct_row_stage_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_row    (in_row),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/idct_row_stage_test.sv
module idct_row_stage_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_row = '0;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    idct_row_stage uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_row    (in_row),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pack8(input int v0, input int v1, input int v2, input int v3,
                                           input int v4, input int v5, input int v6, input int v7);
        return {16'(v7), 16'(v6), 16'(v5), 16'(v4), 16'(v3), 16'(v2), 16'(v1), 16'(v0)};
    endfunction

    function automatic int sat_ref(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // independent integer model of one row
    function automatic logic [127:0] ref_row(input int row, input logic [127:0] d);
        int x[8];
        int c4, c2, c6, c1, c3, c5, c7, rnd;
        int a[4];
        int b[4];
        logic [127:0] r;
        for (int i = 0; i < 8; i++) x[i] = int'($signed(d[16*i +: 16]));
        case (row)
            0, 4: begin c4='h4000; c2='h539f; c6='h22a3; c1='h58c5; c3='h4b42; c5='h3249; c7='h11a8; end
            1, 7: begin c4='h58c5; c2='h73fc; c6='h300b; c1='h7b21; c3='h6862; c5='h45bf; c7='h187e; end
            2, 6: begin c4='h539f; c2='h6d41; c6='h2d41; c1='h73fc; c3='h6254; c5='h41b3; c7='h1712; end
            default: begin c4='h4b42; c2='h6254; c6='h28ba; c1='h6862; c3='h587e; c5='h3b21; c7='h14c3; end
        endcase
        case (row)
            0: rnd = 65536; 1: rnd = 3597; 2: rnd = 2260; 3: rnd = 1203;
            4: rnd = 0;     5: rnd = 120;  default: rnd = 512;
        endcase
        a[0] = c4*x[0] + c2*x[2] + c4*x[4] + c6*x[6] + rnd;
        a[1] = c4*x[0] + c6*x[2] - c4*x[4] - c2*x[6] + rnd;
        a[2] = c4*x[0] - c6*x[2] - c4*x[4] + c2*x[6] + rnd;
        a[3] = c4*x[0] - c2*x[2] + c4*x[4] - c6*x[6] + rnd;
        b[0] = c1*x[1] + c3*x[3] + c5*x[5] + c7*x[7];
        b[1] = c3*x[1] - c7*x[3] - c1*x[5] - c5*x[7];
        b[2] = c5*x[1] - c1*x[3] + c7*x[5] + c3*x[7];
        b[3] = c7*x[1] - c5*x[3] + c3*x[5] - c1*x[7];
        for (int k = 0; k < 4; k++) begin
            r[16*k +: 16]     = 16'(sat_ref((a[k] + b[k]) >>> 11));
            r[16*(7-k) +: 16] = 16'(sat_ref((a[k] - b[k]) >>> 11));
        end
        return r;
    endfunction

    // send one row, measure latency, check result, drain it
    task automatic run_row(input int row, input logic [127:0] d, input string req);
        int lat;
        bit busy_ok;
        logic [127:0] exp;
        exp = ref_row(row, d);
        @(negedge clk);
        check({req, " R8 ready before send"}, 128'(in_ready), 128'(1));
        in_valid = 1'b1;
        in_row   = 3'(row);
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        lat = 0;
        busy_ok = 1'b1;
        while (!out_valid && lat < 20) begin
            if (in_ready) busy_ok = 1'b0;
            lat++;
            @(negedge clk);
        end
        if (in_ready) busy_ok = 1'b0;
        check({req, " R8 ready low while busy"}, 128'(busy_ok), 128'(1));
        check({req, (d == '0) ? " R6 latency" : " R7 latency"}, 128'(lat), (d == '0) ? 128'(0) : 128'(4));
        check({req, " data"}, out_data, exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check({req, " R8 back to idle"}, {126'(0), out_valid, in_ready}, 128'b01);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid/in_ready", {126'(0), out_valid, in_ready}, 128'b01);
        check("R1 reset out_data", out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle after reset", {126'(0), out_valid, in_ready}, 128'b01);
    endtask

    task automatic test_zero_rows();
        for (int r = 0; r < 8; r++) begin
            int v;
            v = (r == 0) ? 32 : ((r == 1 || r == 2) ? 1 : 0);
            run_row(r, '0, $sformatf("R6 zero row %0d", r));
            check($sformatf("R6 zero row %0d literal", r), out_data, {8{16'(v)}});
        end
    endtask

    task automatic test_dc_rows();
        run_row(0, pack8(100, 0, 0, 0, 0, 0, 0, 0), "R3 R4 dc row0");
        check("R3 R4 dc row0 literal", out_data, {8{16'd832}});
        run_row(4, pack8(100, 0, 0, 0, 0, 0, 0, 0), "R4 dc row4");
        run_row(1, pack8(-50, 0, 0, 0, 0, 0, 0, 0), "R3 dc row1");
    endtask

    task automatic test_mixed_rows();
        for (int r = 0; r < 8; r++) begin
            run_row(r, pack8(300, -700, 1100, -1500, 1900, -2300, 2700, -3100),
                    $sformatf("R2 R3 ramp row %0d", r));
        end
        run_row(5, pack8(0, 4000, 0, 0, 0, 0, 0, 0), "R2 odd only row5");
        run_row(6, pack8(0, 0, 0, 0, 0, 0, 5000, 0), "R2 single x6 row6");
        run_row(3, pack8(-1, 1, -1, 1, -1, 1, -1, 1), "R2 tiny row3");
    endtask

    task automatic test_saturation();
        run_row(0, pack8(32767, 0, 0, 0, 0, 0, 0, 0), "R5 dc max row0");
        check("R5 dc max literal", out_data, {8{16'h7fff}});
        run_row(0, pack8(-32768, 0, 0, 0, 0, 0, 0, 0), "R5 dc min row0");
        check("R5 dc min literal", out_data, {8{16'h8000}});
        run_row(1, {8{16'h7fff}}, "R2 R5 full-scale row1");
        run_row(2, pack8(-32768, 32767, -32768, 32767, -32768, 32767, -32768, 32767), "R5 alternating row2");
    endtask

    task automatic test_backpressure();
        logic [127:0] held;
        int lat;
        @(negedge clk);
        in_valid = 1'b1;
        in_row   = 3'd2;
        in_data  = pack8(800, 200, -400, 0, 90, -60, 10, 5);
        @(negedge clk);
        in_data  = pack8(1, 2, 3, 4, 5, 6, 7, 8);
        in_row   = 3'd7;
        lat = 0;
        while (!out_valid && lat < 20) begin
            lat++;
            @(negedge clk);
        end
        held = out_data;
        check("R2 backpressure row2 data", held, ref_row(2, pack8(800, 200, -400, 0, 90, -60, 10, 5)));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 held valid", 128'(out_valid), 128'(1));
            check("R9 held data", out_data, held);
            check("R8 offered input ignored", 128'(in_ready), 128'(0));
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        @(negedge clk);
        check("R8 ignored row not queued", {126'(0), out_valid, in_ready}, 128'b01);
    endtask

    initial begin
        test_reset();
        test_zero_rows();
        test_dc_rows();
        test_mixed_rows();
        test_saturation();
        test_backpressure();
        summary();
    end

endmodule